// File: doc/BRIEF.md
# Decimating Loop Recorder

This block captures a stream of signed 8-bit audio samples into an on-chip memory and later replays them in an endless loop. A level input chooses the mode: low records, high plays back. A sample strobe marks each new incoming sample in record mode, and each request for an outgoing sample in playback mode. Only the rising edge of the strobe counts, so a strobe held high for several clocks still stands for one sample.

While recording, the block keeps one incoming sample in every `DECIM` and writes it to consecutive memory words from address 0. It remembers the last address written. When every word has been written, it stops storing and ignores further samples. In playback, the block fetches one stored word per `DECIM` strobes and holds it on the output for all `DECIM` strobes. This replication brings the reduced rate back up to the strobe rate. After the last recorded word, playback returns to word 0.

The sample stream has no back-pressure. The block accepts every strobe on the clock edge where it is seen, and it always has an output sample ready. Both directions therefore behave as a valid/ready stream whose ready is tied high. The memory has `2**ADDR_W` words; `ADDR_W = 16` gives 65536 words. It is modelled inside the block as a synchronous-read array.

Top module: `loop_recorder`

## Requirements
- R1: While reset is high and on the first clock after it is released, `sample_out` is 0.
- R2: Each 0-to-1 transition of `strobe` counts as exactly one strobe event, however long `strobe` stays high.
- R3: In record mode, the first strobe event after entering the mode stores `sample_in` at word 0. After that, the first of every `DECIM` events stores `sample_in` at the next consecutive address.
- R4: After all `2**ADDR_W` words have been written in one recording, further samples are ignored. Word 0 and the stored words are kept, and playback loops over exactly `2**ADDR_W` words.
- R5: In playback mode, the first strobe event after entering the mode puts word 0 on `sample_out`, in the clock cycle after the edge that captured the strobe. A new word appears on every `DECIM`-th event after that, and each word is repeated for `DECIM` events.
- R6: In playback, the word after the last word written in the most recent recording is word 0, so the recording repeats without end.
- R7: `sample_out` changes only on a clock edge that captures a strobe event or a mode change. With no strobe, it holds its value.
- R8: In record mode, `sample_out` is 0.
- R9: A change of `play` resets the address and the `DECIM` phase. A strobe rising edge seen in the same cycle as the mode change is discarded.
- R10: If playback starts with no word recorded since the last entry to record mode, or since reset, `sample_out` stays 0.
- R11: Entering record mode discards the previous recording. Playback then loops only over the words of the new recording.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all ports are synchronous to it |
| rst | input | 1 | Synchronous reset, active high |
| play | input | 1 | Mode select: 1 = playback, 0 = record |
| strobe | input | 1 | Sample strobe; its rising edge marks a sample event |
| sample_in | input | 8 | Incoming signed two's complement sample, valid when the strobe rise is seen |
| sample_out | output | 8 | Outgoing signed two's complement sample, held between strobe events |

## Verification
A phase counter that is off by one shows up at the ports within `DECIM` strobe events, as a word change at the wrong strobe. A wrong address or high-water mark shows up as a wrong word, or as a wrong loop length, within one pass of the recording. A missing full condition lets later samples overwrite word 0, and this is visible at the very first playback strobe. A mode change that fails to clear the phase shifts every word boundary that follows.

// File: rtl/loop_rec_pkg.sv
package loop_rec_pkg;
  localparam int SAMPLE_W = 8;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/sample_ram.sv
module sample_ram
  import loop_rec_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  sample_t           wdata,
  input  logic [ADDR_W-1:0] raddr,
  output sample_t           rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  sample_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rec_sequencer.sv
module rec_sequencer #(
  parameter int ADDR_W = 11,
  parameter int DECIM  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              play,
  input  logic              tick,
  output logic              mode_chg,
  output logic              play_q,
  output logic              wr_en,
  output logic              take,
  output logic              have_q,
  output logic              full_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [ADDR_W-1:0] hw_q
);
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;
  localparam logic [PH_W-1:0]   PH_LAST  = PH_W'(DECIM - 1);

  logic [PH_W-1:0] phase_q;
  logic            act;
  logic            first_ph;

  assign mode_chg = play ^ play_q;
  assign act      = tick & ~mode_chg;
  assign first_ph = (phase_q == '0);
  assign wr_en    = act & ~play_q & first_ph & ~full_q;
  assign take     = act & play_q & first_ph;

  always_comb begin
    if (mode_chg)
      addr_nxt = '0;
    else if (wr_en)
      addr_nxt = addr_q + 1'b1;
    else if (take && have_q)
      addr_nxt = (addr_q == hw_q) ? '0 : addr_q + 1'b1;
    else
      addr_nxt = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      play_q  <= 1'b0;
      phase_q <= '0;
      addr_q  <= '0;
      hw_q    <= '0;
      full_q  <= 1'b0;
      have_q  <= 1'b0;
    end else begin
      play_q <= play;
      addr_q <= addr_nxt;
      if (mode_chg)
        phase_q <= '0;
      else if (act)
        phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
      if (mode_chg && !play) begin
        full_q <= 1'b0;
        have_q <= 1'b0;
      end else if (wr_en) begin
        hw_q   <= addr_q;
        have_q <= 1'b1;
        if (addr_q == TOP_ADDR) full_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/loop_recorder.sv
module loop_recorder
  import loop_rec_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DECIM  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       play,
  input  logic       strobe,
  input  logic [7:0] sample_in,
  output logic [7:0] sample_out
);
  logic              tick;
  logic              mode_chg;
  logic              play_q;
  logic              wr_en;
  logic              take;
  logic              have_q;
  logic              full_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [ADDR_W-1:0] hw_q;
  sample_t           rd_data;
  sample_t           out_q;

  strobe_rise u_rise (
    .clk   (clk),
    .rst   (rst),
    .level (strobe),
    .rise  (tick)
  );

  rec_sequencer #(.ADDR_W(ADDR_W), .DECIM(DECIM)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .play     (play),
    .tick     (tick),
    .mode_chg (mode_chg),
    .play_q   (play_q),
    .wr_en    (wr_en),
    .take     (take),
    .have_q   (have_q),
    .full_q   (full_q),
    .addr_q   (addr_q),
    .addr_nxt (addr_nxt),
    .hw_q     (hw_q)
  );

  sample_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (addr_q),
    .wdata (sample_t'(sample_in)),
    .raddr (addr_nxt),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst || mode_chg) out_q <= '0;
    else if (take)       out_q <= have_q ? rd_data : '0;
  end

  assign sample_out = out_q;
endmodule

// File: rtl/loop_recorder_chk.sv
module loop_recorder_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              mode_chg,
  input logic              play_q,
  input logic              wr_en,
  input logic              have_q,
  input logic              full_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [ADDR_W-1:0] hw_q,
  input logic [7:0]        sample_out
);
  // R7
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !mode_chg) |=> $stable(sample_out));

  // R8
  record_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !play_q |-> (sample_out == 8'd0));

  // R4
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    full_q |-> !wr_en);

  // R9
  entry_clears_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (addr_q == '0));

  // R3
  write_advances_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_q != '1) |=> (addr_q == ADDR_W'($past(addr_q) + 1)));

  // R6
  loop_within_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (play_q && have_q) |-> (addr_q <= hw_q));
endmodule

bind loop_recorder loop_recorder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .mode_chg   (mode_chg),
  .play_q     (play_q),
  .wr_en      (wr_en),
  .have_q     (have_q),
  .full_q     (full_q),
  .addr_q     (addr_q),
  .hw_q       (hw_q),
  .sample_out (sample_out)
);

// File: tb/loop_recorder_tb.sv
module loop_recorder_tb;
  localparam int ADDR_W = 4;
  localparam int DECIM  = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic       clk = 1'b0;
  logic       rst;
  logic       play;
  logic       strobe;
  logic [7:0] sample_in;
  logic [7:0] sample_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  loop_recorder #(.ADDR_W(ADDR_W), .DECIM(DECIM)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .play       (play),
    .strobe     (strobe),
    .sample_in  (sample_in),
    .sample_out (sample_out)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] wval(input int k, input int seed);
    return 8'(k * 53 + seed * 17 + 11);
  endfunction

  task automatic pulse(input logic [7:0] d, input logic [7:0] e, input string tag);
    @(negedge clk);
    sample_in = d;
    strobe    = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic mode_pulse(input logic p, input string tag);
    @(negedge clk);
    play      = p;
    sample_in = 8'hA5;
    strobe    = 1'b1;
    exp_q.push_back(8'd0);
    tag_q.push_back(tag);
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic record_words(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = wval(k, seed);
      if (k < DEPTH) model[k] = v;
      pulse(v, 8'd0, "R8 R3 record");
      for (int j = 1; j < DECIM; j++) pulse(~v ^ 8'(j), 8'd0, "R8 record");
    end
  endtask

  task automatic play_range(input int start, input int count, input int nwords, input string tag);
    for (int i = start; i < start + count; i++)
      pulse(8'h3C, model[(i / DECIM) % nwords], tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() != 0) begin
        @(negedge clk);
        check(sample_out, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    rst = 1'b1; play = 1'b1; strobe = 1'b0; sample_in = 8'd0;
    repeat (5) @(negedge clk);
    check(sample_out, 8'd0, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check(sample_out, 8'd0, "R1 after reset");

    // R10: playback with nothing recorded
    for (int i = 0; i < 10; i++) pulse(8'h11, 8'd0, "R10 empty playback");

    // R3: record five words
    @(negedge clk); play = 1'b0;
    repeat (2) @(negedge clk);
    record_words(5, 1);

    // R5 R6: play two full loops plus one word
    @(negedge clk); play = 1'b1;
    repeat (2) @(negedge clk);
    play_range(0, 11 * DECIM, 5, "R5 R6 replay loop");

    // R7: idle strobe, output holds
    held = sample_out;
    repeat (10) @(negedge clk);
    check(sample_out, held, "R7 hold without strobe");

    // R2: a long strobe is one event (word index 11 mod 5 = 1)
    @(negedge clk);
    strobe = 1'b1; sample_in = 8'h3C;
    exp_q.push_back(model[1]); tag_q.push_back("R2 long strobe");
    repeat (4) @(negedge clk);
    strobe = 1'b0;
    play_range(11 * DECIM + 1, 2 * DECIM, 5, "R2 count after long strobe");

    // R9 R11: strobe on mode change is discarded; new recording replaces old
    mode_pulse(1'b0, "R9 discard on entry to record");
    record_words(3, 7);
    mode_pulse(1'b1, "R9 discard on entry to playback");
    play_range(0, 7 * DECIM, 3, "R11 new recording loop");

    // R4: overfill the memory
    @(negedge clk); play = 1'b0;
    repeat (2) @(negedge clk);
    record_words(DEPTH + 4, 3);
    @(negedge clk); play = 1'b1;
    repeat (2) @(negedge clk);
    play_range(0, (DEPTH + 2) * DECIM, DEPTH, "R4 full memory loop");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule